// File: doc/BRIEF.md
# Fully Associative Address-Space-Tagged Translation Buffer

This block holds a small, fully associative set of virtual-page to physical-page mappings. Each slot carries a page tag, a physical page number, an address-space identifier, a global flag, per-mode read and write enable masks and two fault-on-access flags. A lookup compares the requested page against every valid slot. It counts as a hit when the tags are equal and the slot is either global or owned by the requesting address space. The block reports hit or miss and returns the stored fields one cycle later. Permission checks and fault generation are left to the caller.

New mappings go into the slot named by a rotating victim pointer, whatever that slot holds. A read-index command shows the slot under the pointer and can step the pointer on. Three invalidation commands are provided: clear everything, drop every non-global slot, and drop the slots that match one page in the current address space. A three-slot shortcut of recently hit slot numbers is searched before the full array. Any insert or invalidation empties it.

Only one command is accepted per cycle, on a 3-bit `op` input. The encoding is 0 idle, 1 lookup, 2 insert, 3 read-index, 4 flush-all, 5 flush-non-global and 6 flush-page.

Top module: `xlat_cache`

## Requirements
- R1: A lookup (op=1) hits a valid slot only when the slot tag equals `op_vpn` and either the slot's global flag is set or its stored identifier equals `op_asn`; otherwise it reports a miss with `rsp_idx` and every field output zero.
- R2: When several slots match a lookup that the shortcut does not serve, the lowest-numbered matching slot is returned.
- R3: An insert (op=2) writes the `ins_*` fields into the slot under the victim pointer, takes the tag from `op_vpn` and marks the slot valid, replacing any previous occupant.
- R4: Every insert advances the victim pointer by one, and the pointer wraps from ENTRIES-1 to 0. Valid slots are therefore overwritten in rotating order.
- R5: Read-index (op=3) returns the slot under the victim pointer: `rsp_idx` is the pointer, `rsp_hit` is the slot's valid flag, and the outputs carry its fields. The pointer advances only when `op_adv` is 1.
- R6: Flush-all (op=4) invalidates and zeroes every slot and returns the victim pointer to 0.
- R7: Flush-non-global (op=5) invalidates every slot whose global flag is clear and keeps global slots usable.
- R8: Flush-page (op=6) invalidates every valid slot whose tag equals `op_vpn` and that is global or carries identifier `op_asn`. It leaves all other slots intact.
- R9: A lookup served from the shortcut sets `rsp_recent`. A hit taken from the full array puts that slot at the front of the three-entry shortcut, and the oldest entry drops out.
- R10: Any insert or flush empties the shortcut, so the next hit comes from the full array with `rsp_recent` low.
- R11: `rsp_valid` rises exactly one cycle after a lookup or read-index and is low after idle, insert or flush cycles. After reset all slots are invalid and the victim pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op | input | 3 | Command code (see above) |
| op_vpn | input | VPN_W | Virtual page for lookup, insert and flush-page |
| op_asn | input | ASN_W | Current address-space identifier for lookup and flush-page |
| op_adv | input | 1 | Read-index: advance the victim pointer |
| ins_ppn | input | PPN_W | Insert: physical page |
| ins_asn | input | ASN_W | Insert: owning address space |
| ins_global | input | 1 | Insert: global flag |
| ins_rd_mask | input | MODES | Insert: read enable per mode |
| ins_wr_mask | input | MODES | Insert: write enable per mode |
| ins_fault_rd | input | 1 | Insert: fault-on-read flag |
| ins_fault_wr | input | 1 | Insert: fault-on-write flag |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Lookup hit, or slot valid for read-index |
| rsp_recent | output | 1 | Hit served by the shortcut |
| rsp_idx | output | IDX_W | Slot number |
| rsp_tag | output | VPN_W | Slot tag |
| rsp_ppn | output | PPN_W | Slot physical page |
| rsp_asn | output | ASN_W | Slot address space |
| rsp_global | output | 1 | Slot global flag |
| rsp_rd_mask | output | MODES | Slot read enables |
| rsp_wr_mask | output | MODES | Slot write enables |
| rsp_fault_rd | output | 1 | Slot fault-on-read |
| rsp_fault_wr | output | 1 | Slot fault-on-write |

## Verification
Lookups are run with the owning identifier, with a foreign identifier and against a global slot, which separates the tag test from the address-space test. The same page is stored under several identifiers and as a global copy, so lowest-index selection and the selective flush-page can be told apart from a plain tag match. Repeated lookups before and after inserts, and a run of four distinct hits, show whether an answer came from the shortcut and whether it was emptied and aged correctly. Filling past the slot count exposes the pointer wrap and the overwrite of valid slots.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   typedef enum logic [2:0] {
      OP_IDLE       = 3'd0,
      OP_LOOKUP     = 3'd1,
      OP_INSERT     = 3'd2,
      OP_READIDX    = 3'd3,
      OP_FLUSH_ALL  = 3'd4,
      OP_FLUSH_PROC = 3'd5,
      OP_FLUSH_PAGE = 3'd6
   } xlat_op_e;
endpackage

// File: rtl/xlat_match.sv
// Per-slot comparator bank: tag equality plus global-or-identifier rule.
module xlat_match #(
   parameter int ENTRIES = 64,
   parameter int VPN_W   = 20,
   parameter int ASN_W   = 8
) (
   input  logic [VPN_W-1:0] tag_i [ENTRIES],
   input  logic [ASN_W-1:0] asn_i [ENTRIES],
   input  logic [ENTRIES-1:0] glob_i,
   input  logic [ENTRIES-1:0] valid_i,
   input  logic [VPN_W-1:0] vpn_i,
   input  logic [ASN_W-1:0] cur_asn_i,
   output logic [ENTRIES-1:0] match_o
);
   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign match_o[e] = valid_i[e] && (tag_i[e] == vpn_i) &&
                          (glob_i[e] || (asn_i[e] == cur_asn_i));
   end
endmodule

// File: rtl/xlat_prio.sv
// Lowest-index-wins encoder over the match vector.
module xlat_prio #(
   parameter int N = 64,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req_i,
   output logic          any_o,
   output logic [IW-1:0] idx_o
);
   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IW'(i);
      end
      any_o = |req_i;
   end
endmodule

// File: rtl/xlat_recent.sv
// Shortcut of recently hit slot numbers, searched in slot order.
module xlat_recent #(
   parameter int ENTRIES = 64,
   parameter int SLOTS   = 3,
   localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] match_i,
   input  logic               clear_i,
   input  logic               push_i,
   input  logic [IW-1:0]      push_idx_i,
   output logic               hit_o,
   output logic [IW-1:0]      hit_idx_o
);
   logic [IW-1:0] slot_idx [SLOTS];
   logic          slot_v   [SLOTS];

   if (SLOTS < 1) begin : g_bad_slots
      $error("xlat_recent: SLOTS must be at least 1");
   end

   always_comb begin
      hit_o     = 1'b0;
      hit_idx_o = '0;
      for (int s = SLOTS - 1; s >= 0; s--) begin
         if (slot_v[s] && match_i[slot_idx[s]]) begin
            hit_o     = 1'b1;
            hit_idx_o = slot_idx[s];
         end
      end
   end

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      if (s == 0) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n || clear_i) begin
               slot_v[s]   <= 1'b0;
               slot_idx[s] <= '0;
            end else if (push_i) begin
               slot_v[s]   <= 1'b1;
               slot_idx[s] <= push_idx_i;
            end
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (!rst_n || clear_i) begin
               slot_v[s]   <= 1'b0;
               slot_idx[s] <= '0;
            end else if (push_i) begin
               slot_v[s]   <= slot_v[s-1];
               slot_idx[s] <= slot_idx[s-1];
            end
         end
      end

      // R10: an insert or flush leaves this slot empty
      assert_recent_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
         clear_i |=> !slot_v[s]);
   end

   // R9: an array hit lands at the front of the shortcut
   assert_recent_front_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !clear_i) |=> (slot_v[0] && slot_idx[0] == $past(push_idx_i)));
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
   import xlat_pkg::*;
#(
   parameter int ENTRIES = 64,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   parameter int ASN_W   = 8,
   parameter int MODES   = 4,
   parameter int RECENT  = 3,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       op,
   input  logic [VPN_W-1:0] op_vpn,
   input  logic [ASN_W-1:0] op_asn,
   input  logic             op_adv,
   input  logic [PPN_W-1:0] ins_ppn,
   input  logic [ASN_W-1:0] ins_asn,
   input  logic             ins_global,
   input  logic [MODES-1:0] ins_rd_mask,
   input  logic [MODES-1:0] ins_wr_mask,
   input  logic             ins_fault_rd,
   input  logic             ins_fault_wr,
   output logic             rsp_valid,
   output logic             rsp_hit,
   output logic             rsp_recent,
   output logic [IDX_W-1:0] rsp_idx,
   output logic [VPN_W-1:0] rsp_tag,
   output logic [PPN_W-1:0] rsp_ppn,
   output logic [ASN_W-1:0] rsp_asn,
   output logic             rsp_global,
   output logic [MODES-1:0] rsp_rd_mask,
   output logic [MODES-1:0] rsp_wr_mask,
   output logic             rsp_fault_rd,
   output logic             rsp_fault_wr
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("xlat_cache: ENTRIES must be at least 2");
   end
   if (VPN_W < 1 || PPN_W < 1 || ASN_W < 1 || MODES < 1) begin : g_bad_width
      $error("xlat_cache: field widths must be positive");
   end

   // Slot storage
   logic [ENTRIES-1:0] valid_q;
   logic [ENTRIES-1:0] glob_q;
   logic [VPN_W-1:0]   tag_q   [ENTRIES];
   logic [PPN_W-1:0]   ppn_q   [ENTRIES];
   logic [ASN_W-1:0]   asn_q   [ENTRIES];
   logic [MODES-1:0]   rdm_q   [ENTRIES];
   logic [MODES-1:0]   wrm_q   [ENTRIES];
   logic [ENTRIES-1:0] frd_q;
   logic [ENTRIES-1:0] fwr_q;
   logic [IDX_W-1:0]   ptr_q;

   xlat_op_e opv;
   assign opv = xlat_op_e'(op);

   logic is_lookup, is_readidx, is_insert, clears_recent;
   assign is_lookup     = (opv == OP_LOOKUP);
   assign is_readidx    = (opv == OP_READIDX);
   assign is_insert     = (opv == OP_INSERT);
   assign clears_recent = is_insert || (opv == OP_FLUSH_ALL) ||
                          (opv == OP_FLUSH_PROC) || (opv == OP_FLUSH_PAGE);

   // Shared comparator bank serves lookup and flush-page
   logic [ENTRIES-1:0] match_vec;
   xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) i_match (
      .tag_i(tag_q), .asn_i(asn_q), .glob_i(glob_q), .valid_i(valid_q),
      .vpn_i(op_vpn), .cur_asn_i(op_asn), .match_o(match_vec)
   );

   logic             arr_hit;
   logic [IDX_W-1:0] arr_idx;
   xlat_prio #(.N(ENTRIES)) i_prio (
      .req_i(match_vec), .any_o(arr_hit), .idx_o(arr_idx)
   );

   logic             rec_hit;
   logic [IDX_W-1:0] rec_idx;
   logic             rec_push;
   assign rec_push = is_lookup && !rec_hit && arr_hit;

   xlat_recent #(.ENTRIES(ENTRIES), .SLOTS(RECENT)) i_recent (
      .clk(clk), .rst_n(rst_n), .match_i(match_vec),
      .clear_i(clears_recent), .push_i(rec_push), .push_idx_i(arr_idx),
      .hit_o(rec_hit), .hit_idx_o(rec_idx)
   );

   logic [IDX_W-1:0] ptr_inc;
   assign ptr_inc = (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;

   // Slot state and victim pointer
   always_ff @(posedge clk) begin
      if (!rst_n || opv == OP_FLUSH_ALL) begin
         valid_q <= '0;
         glob_q  <= '0;
         frd_q   <= '0;
         fwr_q   <= '0;
         ptr_q   <= '0;
         for (int e = 0; e < ENTRIES; e++) begin
            tag_q[e] <= '0;
            ppn_q[e] <= '0;
            asn_q[e] <= '0;
            rdm_q[e] <= '0;
            wrm_q[e] <= '0;
         end
      end else begin
         case (opv)
            OP_INSERT: begin
               valid_q[ptr_q] <= 1'b1;
               glob_q[ptr_q]  <= ins_global;
               frd_q[ptr_q]   <= ins_fault_rd;
               fwr_q[ptr_q]   <= ins_fault_wr;
               tag_q[ptr_q]   <= op_vpn;
               ppn_q[ptr_q]   <= ins_ppn;
               asn_q[ptr_q]   <= ins_asn;
               rdm_q[ptr_q]   <= ins_rd_mask;
               wrm_q[ptr_q]   <= ins_wr_mask;
               ptr_q          <= ptr_inc;
            end
            OP_READIDX:    if (op_adv) ptr_q <= ptr_inc;
            OP_FLUSH_PROC: valid_q <= valid_q & glob_q;
            OP_FLUSH_PAGE: valid_q <= valid_q & ~match_vec;
            default: ;
         endcase
      end
   end

   // Registered response
   logic             sel_show;
   logic             sel_hit;
   logic [IDX_W-1:0] sel_idx;
   always_comb begin
      if (is_readidx) begin
         sel_idx  = ptr_q;
         sel_hit  = valid_q[ptr_q];
         sel_show = 1'b1;
      end else begin
         sel_idx  = rec_hit ? rec_idx : arr_idx;
         sel_hit  = rec_hit || arr_hit;
         sel_show = sel_hit;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid    <= 1'b0;
         rsp_hit      <= 1'b0;
         rsp_recent   <= 1'b0;
         rsp_idx      <= '0;
         rsp_tag      <= '0;
         rsp_ppn      <= '0;
         rsp_asn      <= '0;
         rsp_global   <= 1'b0;
         rsp_rd_mask  <= '0;
         rsp_wr_mask  <= '0;
         rsp_fault_rd <= 1'b0;
         rsp_fault_wr <= 1'b0;
      end else begin
         rsp_valid <= is_lookup || is_readidx;
         if (is_lookup || is_readidx) begin
            rsp_hit      <= sel_hit;
            rsp_recent   <= is_lookup && rec_hit;
            rsp_idx      <= sel_show ? sel_idx : '0;
            rsp_tag      <= sel_show ? tag_q[sel_idx] : '0;
            rsp_ppn      <= sel_show ? ppn_q[sel_idx] : '0;
            rsp_asn      <= sel_show ? asn_q[sel_idx] : '0;
            rsp_global   <= sel_show && glob_q[sel_idx];
            rsp_rd_mask  <= sel_show ? rdm_q[sel_idx] : '0;
            rsp_wr_mask  <= sel_show ? wrm_q[sel_idx] : '0;
            rsp_fault_rd <= sel_show && frd_q[sel_idx];
            rsp_fault_wr <= sel_show && fwr_q[sel_idx];
         end
      end
   end

   // Assertions
   assert_insert_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
      is_insert |=> (valid_q[$past(ptr_q)] && tag_q[$past(ptr_q)] == $past(op_vpn)));

   assert_ptr_rotates_R4: assert property (@(posedge clk) disable iff (!rst_n)
      is_insert |=> (ptr_q == (($past(ptr_q) == LAST_IDX) ? '0 : $past(ptr_q) + 1'b1)));

   assert_readidx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (is_readidx && !op_adv) |=> $stable(ptr_q));

   assert_flush_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (opv == OP_FLUSH_ALL) |=> (valid_q == '0 && ptr_q == '0));

   assert_flush_proc_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (opv == OP_FLUSH_PROC) |=> ((valid_q & ~glob_q) == '0));

   assert_flush_page_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (opv == OP_FLUSH_PAGE) |=> ((valid_q & ~$past(valid_q)) == '0));

   assert_rsp_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(is_lookup || is_readidx) |=> !rsp_valid);

   assert_miss_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit && !rsp_recent && rsp_idx == '0 && $past(is_lookup))
         |-> (rsp_ppn == '0 && rsp_tag == '0));
endmodule

// File: tb/test_xlat_cache.sv
`timescale 1ns/100ps
module test_xlat_cache;
   localparam int ENTRIES = 64;
   localparam int VPN_W = 20, PPN_W = 20, ASN_W = 8, MODES = 4;
   localparam int IDX_W = $clog2(ENTRIES);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0] op = 3'd0;
   logic [VPN_W-1:0] op_vpn = '0;
   logic [ASN_W-1:0] op_asn = '0;
   logic op_adv = 1'b0;
   logic [PPN_W-1:0] ins_ppn = '0;
   logic [ASN_W-1:0] ins_asn = '0;
   logic ins_global = 1'b0;
   logic [MODES-1:0] ins_rd_mask = '0, ins_wr_mask = '0;
   logic ins_fault_rd = 1'b0, ins_fault_wr = 1'b0;
   logic rsp_valid, rsp_hit, rsp_recent, rsp_global, rsp_fault_rd, rsp_fault_wr;
   logic [IDX_W-1:0] rsp_idx;
   logic [VPN_W-1:0] rsp_tag;
   logic [PPN_W-1:0] rsp_ppn;
   logic [ASN_W-1:0] rsp_asn;
   logic [MODES-1:0] rsp_rd_mask, rsp_wr_mask;

   int n_checks = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   xlat_cache #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W),
                .ASN_W(ASN_W), .MODES(MODES)) i_xlat_cache (
      .clk(clk), .rst_n(rst_n), .op(op), .op_vpn(op_vpn), .op_asn(op_asn),
      .op_adv(op_adv), .ins_ppn(ins_ppn), .ins_asn(ins_asn),
      .ins_global(ins_global), .ins_rd_mask(ins_rd_mask),
      .ins_wr_mask(ins_wr_mask), .ins_fault_rd(ins_fault_rd),
      .ins_fault_wr(ins_fault_wr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
      .rsp_recent(rsp_recent), .rsp_idx(rsp_idx), .rsp_tag(rsp_tag),
      .rsp_ppn(rsp_ppn), .rsp_asn(rsp_asn), .rsp_global(rsp_global),
      .rsp_rd_mask(rsp_rd_mask), .rsp_wr_mask(rsp_wr_mask),
      .rsp_fault_rd(rsp_fault_rd), .rsp_fault_wr(rsp_fault_wr)
   );

   function automatic logic [PPN_W-1:0] ppn_of(input logic [VPN_W-1:0] v);
      return PPN_W'(v + 20'h05000);
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Drive one command for one cycle; response is sampled on return.
   task automatic issue(input logic [2:0] c);
      @(negedge clk);
      op = c;
      @(negedge clk);
      op = 3'd0;
   endtask

   task automatic insert(input logic [VPN_W-1:0] v, input logic [ASN_W-1:0] a,
                         input logic g);
      op_vpn = v; ins_asn = a; ins_global = g; ins_ppn = ppn_of(v);
      ins_rd_mask = v[3:0]; ins_wr_mask = ~v[3:0];
      ins_fault_rd = v[4]; ins_fault_wr = v[5];
      issue(3'd2);
   endtask

   task automatic lookup(input logic [VPN_W-1:0] v, input logic [ASN_W-1:0] a);
      op_vpn = v; op_asn = a;
      issue(3'd1);
   endtask

   task automatic expect_hit(input string req, input logic [VPN_W-1:0] v,
                             input int idx, input logic recent);
      chk(req, "rsp_valid", 32'(rsp_valid), 1);
      chk(req, "hit", 32'(rsp_hit), 1);
      chk(req, "idx", 32'(rsp_idx), 32'(idx));
      chk(req, "ppn", 32'(rsp_ppn), 32'(ppn_of(v)));
      chk(req, "recent", 32'(rsp_recent), 32'(recent));
   endtask

   task automatic expect_miss(input string req);
      chk(req, "hit", 32'(rsp_hit), 0);
      chk(req, "miss idx", 32'(rsp_idx), 0);
      chk(req, "miss ppn", 32'(rsp_ppn), 0);
   endtask

   task automatic readidx(input logic adv);
      op_adv = adv;
      issue(3'd3);
      op_adv = 1'b0;
   endtask

   task automatic t_reset;
      chk("R11", "rsp_valid after reset", 32'(rsp_valid), 0);
      readidx(1'b0);
      chk("R11", "pointer after reset", 32'(rsp_idx), 0);
      chk("R11", "slot valid after reset", 32'(rsp_hit), 0);
      lookup(20'h00005, 8'd0);
      expect_miss("R11");
   endtask

   task automatic t_match;
      insert(20'h00100, 8'd3, 1'b0);  // slot 0
      chk("R11", "rsp_valid after insert", 32'(rsp_valid), 0);
      insert(20'h00200, 8'd3, 1'b1);  // slot 1, global
      lookup(20'h00100, 8'd3);
      expect_hit("R3", 20'h00100, 0, 1'b0);
      chk("R3", "rd mask", 32'(rsp_rd_mask), 32'h0);
      chk("R3", "wr mask", 32'(rsp_wr_mask), 32'hF);
      chk("R3", "asn", 32'(rsp_asn), 3);
      lookup(20'h00100, 8'd4);
      expect_miss("R1");
      lookup(20'h00200, 8'd9);
      expect_hit("R1", 20'h00200, 1, 1'b0);
      chk("R1", "global flag", 32'(rsp_global), 1);
   endtask

   task automatic t_recent;
      lookup(20'h00100, 8'd3);
      expect_hit("R9", 20'h00100, 0, 1'b1);
      insert(20'h00300, 8'd3, 1'b0);  // slot 2
      lookup(20'h00100, 8'd3);
      expect_hit("R10", 20'h00100, 0, 1'b0);
      insert(20'h00400, 8'd3, 1'b0);  // slot 3, empties shortcut
      lookup(20'h00100, 8'd3);
      lookup(20'h00200, 8'd3);
      lookup(20'h00300, 8'd3);
      lookup(20'h00400, 8'd3);
      expect_hit("R9", 20'h00400, 3, 1'b0);
      lookup(20'h00100, 8'd3);        // aged out
      expect_hit("R9", 20'h00100, 0, 1'b0);
      lookup(20'h00400, 8'd3);        // still held
      expect_hit("R9", 20'h00400, 3, 1'b1);
   endtask

   task automatic t_dup_and_page;
      insert(20'h00100, 8'd3, 1'b0);  // slot 4, duplicate
      lookup(20'h00100, 8'd3);
      expect_hit("R2", 20'h00100, 0, 1'b0);
      insert(20'h00100, 8'd7, 1'b0);  // slot 5
      insert(20'h00100, 8'd1, 1'b1);  // slot 6, global
      op_vpn = 20'h00100; op_asn = 8'd3;
      issue(3'd6);
      lookup(20'h00100, 8'd3);
      expect_miss("R8");
      lookup(20'h00100, 8'd7);
      expect_hit("R8", 20'h00100, 5, 1'b0);
      lookup(20'h00200, 8'd3);
      expect_hit("R8", 20'h00200, 1, 1'b0);
   endtask

   task automatic t_proc;
      issue(3'd5);
      lookup(20'h00200, 8'h55);
      expect_hit("R7", 20'h00200, 1, 1'b0);
      lookup(20'h00300, 8'd3);
      expect_miss("R7");
      lookup(20'h00100, 8'd7);
      expect_miss("R7");
   endtask

   task automatic t_readidx;
      readidx(1'b0);
      chk("R5", "ptr no advance", 32'(rsp_idx), 7);
      chk("R5", "slot 7 empty", 32'(rsp_hit), 0);
      readidx(1'b1);
      chk("R5", "ptr before advance", 32'(rsp_idx), 7);
      readidx(1'b0);
      chk("R5", "ptr after advance", 32'(rsp_idx), 8);
   endtask

   task automatic t_flush_all;
      issue(3'd4);
      lookup(20'h00200, 8'd3);
      expect_miss("R6");
      readidx(1'b0);
      chk("R6", "ptr reset", 32'(rsp_idx), 0);
      chk("R6", "slot 0 cleared", 32'(rsp_hit), 0);
      chk("R6", "slot 0 tag", 32'(rsp_tag), 0);
   endtask

   task automatic t_wrap;
      for (int i = 0; i <= ENTRIES; i++) insert(VPN_W'(20'h01000 + i), 8'd1, 1'b0);
      lookup(20'h01000, 8'd1);
      expect_miss("R4");
      lookup(VPN_W'(20'h01000 + ENTRIES), 8'd1);
      expect_hit("R4", VPN_W'(20'h01000 + ENTRIES), 0, 1'b0);
      lookup(VPN_W'(20'h01000 + ENTRIES - 1), 8'd1);
      expect_hit("R4", VPN_W'(20'h01000 + ENTRIES - 1), ENTRIES - 1, 1'b0);
      readidx(1'b0);
      chk("R4", "ptr after wrap", 32'(rsp_idx), 1);
      chk("R5", "tag at ptr", 32'(rsp_tag), 32'h01001);
      chk("R5", "slot valid at ptr", 32'(rsp_hit), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_match();
      t_recent();
      t_dup_and_page();
      t_proc();
      t_readidx();
      t_flush_all();
      t_wrap();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end
endmodule